// File: doc/BRIEF.md
# Accumulator Stored-Program Controller

This block is a small stored-program processor with a single accumulator. Each instruction is carried out as a fixed series of register transfers. A program counter names the next word. A memory address register drives the address bus. A memory buffer register holds the word that moves between the core and memory. A current instruction register holds the instruction while it is decoded and executed. The block starts fetching at address zero when reset is released and keeps running with no stop condition.

Main memory is a 16-word, single-ported store of 8-bit words, kept outside the block. A read returns the word at the address register in the cycle after that register is loaded, so the buffer register captures it at the next edge. A write happens at the clock edge that ends a cycle in which the write enable is high. The accumulator, the program counter and the three condition flags are brought out as ports so that the surrounding logic can watch the core work.

Each instruction byte holds a 4-bit opcode in its high nibble and a 4-bit direct address or immediate value in its low nibble. A status register keeps carry, zero and overflow bits. Only the arithmetic and logic instructions change it.

Top module: `acs_core`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, the program counter, accumulator, address bus and all three flags read zero and write enable is low. The core begins with the first fetch step.
- R2: The fetch takes three steps. First the address register takes the PC. In the next cycle the PC increments by one, and in that same cycle the buffer register takes the memory word. In the third step the instruction register takes the buffer. A decode step follows and selects the execute sequence from bits 7:4.
- R3: The PC is 4 bits wide and wraps from 15 to 0. It changes only in the second fetch step.
- R4: LOAD (opcode 0x1) sets the address register to bits 3:0, reads that word into the buffer and copies it into the accumulator. The instruction takes 7 cycles in total.
- R5: STORE (opcode 0x2) loads the address register from bits 3:0 and the buffer from the accumulator. It then raises write enable for exactly one cycle, with the address register on the address bus and the buffer on the write data. The instruction takes 6 cycles.
- R6: LOADI (opcode 0xC) sets the accumulator to bits 3:0, zero-extended. The instruction takes 5 cycles.
- R7: NOP (opcode 0x0) and any opcode with no assigned meaning (0x3 to 0x7, 0xD to 0xF) take 4 cycles. They change neither the accumulator nor the flags, and they write no memory.
- R8: ADD (opcode 0x8) reads its operand the same way as LOAD and sets ACC to ACC+M modulo 256. Carry is the 9th sum bit. Zero means the result is 0. Overflow is set when both inputs have the same sign and the result's sign differs from it.
- R9: SUB (opcode 0x9) sets ACC to ACC-M modulo 256. Carry is set when a borrow occurs, that is when ACC < M unsigned. Overflow is set when the inputs differ in sign and the result's sign differs from ACC's.
- R10: AND (opcode 0xA) and OR (opcode 0xB) apply the bitwise operation to ACC and M. They clear carry and overflow, and set zero from the result.
- R11: LOAD, STORE, LOADI and NOP leave all three flags unchanged.
- R12: The buffer register takes the data bus at the edge that ends the cycle after the address register was loaded, and the address bus always shows the address register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 4 | Address bus, driven by the address register |
| mem_wdata | output | 8 | Write data, driven by the buffer register |
| mem_we | output | 1 | Write enable, high for one cycle per STORE |
| mem_rdata | input | 8 | Read data, valid in the cycle after the address register loads |
| acc_o | output | 8 | Accumulator |
| pc_o | output | 4 | Program counter |
| flag_c | output | 1 | Carry or borrow flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Signed overflow flag |

## Verification
A wrong step in the sequencer moves the address bus. The bus then shows the wrong word's address in the very next cycle, one cycle earlier or later than expected, and a per-cycle comparison of the bus catches this at once. A corrupted instruction or buffer register stays hidden until the execute step. It then appears as a wrong operand address two cycles after decode, or as a wrong accumulator or flag value at the end of the instruction. A wrong PC shows up only at the next fetch, when the address register copies it onto the bus.

// File: rtl/acs_pkg.sv
package acs_pkg;

  // opcode codes (high nibble of the instruction byte)
  localparam logic [3:0] OPC_NOP   = 4'h0;
  localparam logic [3:0] OPC_LOAD  = 4'h1;
  localparam logic [3:0] OPC_STORE = 4'h2;
  localparam logic [3:0] OPC_ADD   = 4'h8;
  localparam logic [3:0] OPC_SUB   = 4'h9;
  localparam logic [3:0] OPC_AND   = 4'hA;
  localparam logic [3:0] OPC_OR    = 4'hB;
  localparam logic [3:0] OPC_LDI   = 4'hC;

  typedef enum logic [3:0] {
    S_F1   = 4'd0,  // address register <- PC
    S_F2   = 4'd1,  // PC+1, buffer <- memory
    S_F3   = 4'd2,  // instruction register <- buffer
    S_DEC  = 4'd3,  // pick execute sequence
    S_EA   = 4'd4,  // address register <- operand
    S_ERD  = 4'd5,  // buffer <- memory
    S_EALU = 4'd6,  // accumulator update
    S_EWR  = 4'd7,  // write strobe
    S_EIMM = 4'd8   // accumulator <- immediate
  } state_e;

  typedef struct packed {
    logic mar_from_pc;
    logic mar_from_opr;
    logic pc_inc;
    logic mbr_from_mem;
    logic mbr_from_acc;
    logic cir_load;
    logic acc_from_alu;
    logic acc_from_mbr;
    logic acc_from_imm;
    logic flags_load;
    logic mem_we;
  } ctl_t;

  typedef struct packed {
    logic c;
    logic z;
    logic v;
  } flags_t;

endpackage

// File: rtl/acs_alu.sv
module acs_alu
  import acs_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OPW = 4
) (
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  a,
  input  logic [DW-1:0]  b,
  output logic [DW-1:0]  y,
  output flags_t         fl
);

  localparam int MSB = DW - 1;

  // returns {carry, overflow, result}
  function automatic logic [DW+1:0] alu_eval(input logic [OPW-1:0] o,
                                             input logic [DW-1:0] x,
                                             input logic [DW-1:0] w);
    logic [DW:0]   wide;
    logic [DW-1:0] r;
    logic          cy;
    logic          ov;
    wide = '0;
    r    = x;
    cy   = 1'b0;
    ov   = 1'b0;
    case (o)
      OPW'(OPC_ADD): begin
        wide = {1'b0, x} + {1'b0, w};
        r    = wide[DW-1:0];
        cy   = wide[DW];
        ov   = (x[MSB] == w[MSB]) && (r[MSB] != x[MSB]);
      end
      OPW'(OPC_SUB): begin
        wide = {1'b0, x} - {1'b0, w};
        r    = wide[DW-1:0];
        cy   = wide[DW];
        ov   = (x[MSB] != w[MSB]) && (r[MSB] != x[MSB]);
      end
      OPW'(OPC_AND): r = x & w;
      OPW'(OPC_OR):  r = x | w;
      default:       r = x;
    endcase
    return {cy, ov, r};
  endfunction

  logic [DW+1:0] packed_out;

  always_comb begin
    packed_out = alu_eval(op, a, b);
    y    = packed_out[DW-1:0];
    fl.c = packed_out[DW+1];
    fl.v = packed_out[DW];
    fl.z = (packed_out[DW-1:0] == '0);
  end

endmodule

// File: rtl/acs_ctrl.sv
module acs_ctrl
  import acs_pkg::*;
#(
  parameter int OPW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] op,
  output state_e         state,
  output ctl_t           ctl,
  output logic           seq_last
);

  state_e st_q, st_d;

  function automatic logic reads_operand(input logic [OPW-1:0] o);
    return (o == OPW'(OPC_LOAD)) || (o == OPW'(OPC_ADD)) ||
           (o == OPW'(OPC_SUB))  || (o == OPW'(OPC_AND)) ||
           (o == OPW'(OPC_OR));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_F1;
    else        st_q <= st_d;
  end

  always_comb begin
    ctl  = '0;
    st_d = st_q;
    case (st_q)
      S_F1: begin
        ctl.mar_from_pc = 1'b1;
        st_d = S_F2;
      end
      S_F2: begin
        ctl.pc_inc       = 1'b1;
        ctl.mbr_from_mem = 1'b1;
        st_d = S_F3;
      end
      S_F3: begin
        ctl.cir_load = 1'b1;
        st_d = S_DEC;
      end
      S_DEC: begin
        if (reads_operand(op) || op == OPW'(OPC_STORE)) st_d = S_EA;
        else if (op == OPW'(OPC_LDI))                   st_d = S_EIMM;
        else                                            st_d = S_F1;
      end
      S_EA: begin
        ctl.mar_from_opr = 1'b1;
        if (op == OPW'(OPC_STORE)) begin
          ctl.mbr_from_acc = 1'b1;
          st_d = S_EWR;
        end else begin
          st_d = S_ERD;
        end
      end
      S_ERD: begin
        ctl.mbr_from_mem = 1'b1;
        st_d = S_EALU;
      end
      S_EALU: begin
        if (op == OPW'(OPC_LOAD)) begin
          ctl.acc_from_mbr = 1'b1;
        end else begin
          ctl.acc_from_alu = 1'b1;
          ctl.flags_load   = 1'b1;
        end
        st_d = S_F1;
      end
      S_EWR: begin
        ctl.mem_we = 1'b1;
        st_d = S_F1;
      end
      S_EIMM: begin
        ctl.acc_from_imm = 1'b1;
        st_d = S_F1;
      end
      default: st_d = S_F1;
    endcase
  end

  assign state    = st_q;
  assign seq_last = (st_d == S_F1) && (st_q != S_F1);

endmodule

// File: rtl/acs_datapath.sv
module acs_datapath
  import acs_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctl_t          ctl,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] alu_y,
  input  flags_t        alu_fl,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] mar,
  output logic [DW-1:0] mbr,
  output logic [DW-1:0] cir,
  output logic [DW-1:0] acc,
  output flags_t        flags
);

  localparam int IMM_PAD = DW - AW;

  logic [DW-1:0] imm_ext;
  assign imm_ext = {{IMM_PAD{1'b0}}, cir[AW-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc    <= '0;
      mar   <= '0;
      mbr   <= '0;
      cir   <= '0;
      acc   <= '0;
      flags <= '0;
    end else begin
      if (ctl.mar_from_pc)       mar <= pc;
      else if (ctl.mar_from_opr) mar <= cir[AW-1:0];

      if (ctl.pc_inc) pc <= pc + 1'b1;

      if (ctl.mbr_from_mem)      mbr <= mem_rdata;
      else if (ctl.mbr_from_acc) mbr <= acc;

      if (ctl.cir_load) cir <= mbr;

      if (ctl.acc_from_alu)      acc <= alu_y;
      else if (ctl.acc_from_mbr) acc <= mbr;
      else if (ctl.acc_from_imm) acc <= imm_ext;

      if (ctl.flags_load) flags <= alu_fl;
    end
  end

endmodule

// File: rtl/acs_core.sv
module acs_core
  import acs_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] acc_o,
  output logic [AW-1:0] pc_o,
  output logic          flag_c,
  output logic          flag_z,
  output logic          flag_v
);

  localparam int OPW = DW - AW;

  state_e         state;
  ctl_t           ctl;
  logic           seq_last;
  logic [AW-1:0]  mar;
  logic [DW-1:0]  mbr;
  logic [DW-1:0]  cir;
  logic [DW-1:0]  acc;
  flags_t         flags;
  logic [DW-1:0]  alu_y;
  flags_t         alu_fl;
  logic [OPW-1:0] opcode;

  // named events for the checker
  logic fetch_begin;
  logic pc_step;
  logic mbr_take_mem;
  logic flags_write;

  assign opcode = cir[DW-1 -: OPW];

  acs_ctrl #(.OPW(OPW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (opcode),
    .state    (state),
    .ctl      (ctl),
    .seq_last (seq_last)
  );

  acs_alu #(.DW(DW), .OPW(OPW)) u_alu (
    .op (opcode),
    .a  (acc),
    .b  (mbr),
    .y  (alu_y),
    .fl (alu_fl)
  );

  acs_datapath #(.DW(DW), .AW(AW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .mem_rdata (mem_rdata),
    .alu_y     (alu_y),
    .alu_fl    (alu_fl),
    .pc        (pc_o),
    .mar       (mar),
    .mbr       (mbr),
    .cir       (cir),
    .acc       (acc),
    .flags     (flags)
  );

  assign fetch_begin  = (state == S_F1);
  assign pc_step      = ctl.pc_inc;
  assign mbr_take_mem = ctl.mbr_from_mem;
  assign flags_write  = ctl.flags_load;

  assign mem_addr  = mar;
  assign mem_wdata = mbr;
  assign mem_we    = ctl.mem_we;
  assign acc_o     = acc;
  assign flag_c    = flags.c;
  assign flag_z    = flags.z;
  assign flag_v    = flags.v;

endmodule

// File: rtl/acs_core_chk.sv
module acs_core_chk #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_we,
  input logic [DW-1:0] mem_rdata,
  input logic [DW-1:0] mem_wdata,
  input logic [DW-1:0] acc_o,
  input logic [AW-1:0] pc_o,
  input logic          flag_c,
  input logic          flag_z,
  input logic          flag_v,
  input logic          fetch_begin,
  input logic          pc_step,
  input logic          mbr_take_mem,
  input logic          flags_write,
  input logic          seq_last
);

  assert_we_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  assert_pc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pc_step |=> (pc_o == AW'($past(pc_o) + 1)));

  assert_pc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_step |=> $stable(pc_o));

  assert_flags_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !flags_write |=> $stable({flag_c, flag_z, flag_v}));

  assert_zero_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flags_write |=> (flag_z == (acc_o == '0)));

  assert_buffer_capture_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mbr_take_mem |=> (mem_wdata == $past(mem_rdata)));

  assert_refetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_last |=> fetch_begin);

  assert_no_write_in_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_begin |-> !mem_we);

endmodule

bind acs_core acs_core_chk #(.DW(DW), .AW(AW)) u_chk (.*);

// File: tb/acs_core_bench.sv
module acs_core_bench;

  localparam int DW    = 8;
  localparam int AW    = 4;
  localparam int DEPTH = 16;
  localparam int RUN_CYCLES = 700;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_we;
  logic [DW-1:0] mem_rdata;
  logic [DW-1:0] acc_o;
  logic [AW-1:0] pc_o;
  logic          flag_c, flag_z, flag_v;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  acs_core #(.DW(DW), .AW(AW)) u_acs_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_rdata (mem_rdata),
    .acc_o     (acc_o),
    .pc_o      (pc_o),
    .flag_c    (flag_c),
    .flag_z    (flag_z),
    .flag_v    (flag_v)
  );

  // program image: exercises every opcode class, a carry, signed overflow,
  // a borrow, an undefined opcode and a PC wrap
  function automatic int image(int i);
    case (i)
      0:  return 'hCF; 1:  return 'h8C; 2:  return 'h2D; 3:  return 'h1E;
      4:  return 'h8F; 5:  return 'h9F; 6:  return 'hAC; 7:  return 'hBD;
      8:  return 'h50; 9:  return 'h9C; 10: return 'h2D; 11: return 'h00;
      12: return 'hF1; 13: return 'h00; 14: return 'h7F; default: return 'h01;
    endcase
  endfunction

  // memory seen by the design: read data follows the address bus
  logic [DW-1:0] ram [DEPTH];
  assign mem_rdata = ram[mem_addr];
  always @(posedge clk) if (mem_we) ram[mem_addr] <= mem_wdata;

  // behavioural reference, stepped once per clock
  int m_mem [DEPTH];
  int m_pc, m_mar, m_mbr, m_cir, m_acc, m_c, m_z, m_v, m_ph;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pc = 0; m_mar = 0; m_mbr = 0; m_cir = 0; m_acc = 0;
      m_c = 0; m_z = 0; m_v = 0; m_ph = 0;
      for (int i = 0; i < DEPTH; i++) m_mem[i] = image(i);
    end else begin
      int op, a, b, s, res;
      op = m_cir / 16;
      case (m_ph)
        0: begin m_mar = m_pc; m_ph = 1; end
        1: begin m_mbr = m_mem[m_mar]; m_pc = (m_pc + 1) % 16; m_ph = 2; end
        2: begin m_cir = m_mbr; m_ph = 3; end
        3: begin
          if (op == 1 || op == 2 || (op >= 8 && op <= 11)) m_ph = 4;
          else if (op == 12) m_ph = 7;
          else m_ph = 0;
        end
        4: begin
          m_mar = m_cir % 16;
          if (op == 2) begin m_mbr = m_acc; m_ph = 6; end
          else m_ph = 5;
        end
        5: begin m_mbr = m_mem[m_mar]; m_ph = 8; end
        6: begin m_mem[m_mar] = m_mbr; m_ph = 0; end
        7: begin m_acc = m_cir % 16; m_ph = 0; end
        default: begin
          a = m_acc; b = m_mbr;
          if (op == 1) m_acc = b;
          else begin
            m_c = 0; m_v = 0;
            if (op == 8) begin
              s = a + b; res = s % 256; m_c = (s > 255);
              m_v = ((a < 128) == (b < 128)) && ((res < 128) != (a < 128));
            end else if (op == 9) begin
              s = a - b; res = (s + 256) % 256; m_c = (a < b);
              m_v = ((a < 128) != (b < 128)) && ((res < 128) != (a < 128));
            end else if (op == 10) res = a & b;
            else res = a | b;
            m_z = (res == 0);
            m_acc = res;
          end
          m_ph = 0;
        end
      endcase
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string acc_req(int op);
    case (op)
      1: return "R4"; 2: return "R5"; 8: return "R8"; 9: return "R9";
      10, 11: return "R10"; 12: return "R6"; default: return "R7";
    endcase
  endfunction

  function automatic string flag_req(int op);
    case (op)
      8: return "R8"; 9: return "R9"; 10, 11: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic compare_all();
    int op;
    op = m_cir / 16;
    chk("R12", "address bus", int'(mem_addr), m_mar);
    chk("R5", "write enable", int'(mem_we), (m_ph == 6) ? 1 : 0);
    if (m_ph == 6) chk("R5", "write data", int'(mem_wdata), m_mbr);
    chk("R3", "program counter", int'(pc_o), m_pc);
    chk(acc_req(op), "accumulator", int'(acc_o), m_acc);
    chk(flag_req(op), "flags cZv", int'({flag_c, flag_z, flag_v}),
        m_c * 4 + m_z * 2 + m_v);
  endtask

  initial begin
    rst_n = 1'b0;
    for (int i = 0; i < DEPTH; i++) ram[i] = DW'(image(i));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "pc in reset", int'(pc_o), 0);
    chk("R1", "acc in reset", int'(acc_o), 0);
    chk("R1", "address in reset", int'(mem_addr), 0);
    chk("R1", "flags in reset", int'({flag_c, flag_z, flag_v}), 0);
    chk("R1", "write enable in reset", int'(mem_we), 0);
    rst_n = 1'b1;
    for (int n = 0; n < RUN_CYCLES; n++) begin
      @(negedge clk);
      compare_all();
    end
    // R2: the final contents of the store target
    chk("R2", "stored word 13", int'(ram[13]), m_mem[13]);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule